// File: doc/BRIEF.md
# Oscillator Settle and Readiness Monitor

This block reports when each of four clock sources is fit for use. The four sources are an external crystal, a PLL, a fast on-chip RC and a slow on-chip RC. Each source has a settle counter that runs on the source's own clock. The PLL's counter runs on whichever reference clock is selected. When a counter reaches the threshold for its source, it raises a ready flag. That flag crosses into the system clock domain and appears in a five-bit status word.

The block also tracks a low-power state. A sleep request made while the deep-sleep control is set enters the low-power state, and a wake interrupt leaves it. In the low-power state the crystal, PLL and fast RC flags drop, and the crystal and fast RC oscillator enables are withdrawn. The slow RC keeps its flag. Disabling a source, or moving the PLL to a different reference, drops that source's flag and restarts its count from zero.

Top module: `osc_ready_monitor`

## Requirements
- R1: The crystal flag (status bit 0) sets after 4096 crystal clock cycles of continuous enable, within a few cycles of synchronizer latency.
- R2: The fast RC flag (status bit 4) sets after 256 fast RC cycles, and the slow RC flag (status bit 3) sets after 1 slow RC cycle.
- R3: The PLL flag (status bit 2) sets after 6144 cycles of its reference clock. The reference is the crystal when `pll_ref_sel` is 0 and the fast RC when it is 1. The PLL is enabled while `pll_pd` is 0.
- R4: Status bit 1 always reads 0.
- R5: When a source is disabled (`en_*` low, or `pll_pd` high), its status bit reads 0 from the first system clock edge that samples the change. A later re-enable needs the full settle count again.
- R6: `pd_active` rises on the edge after `sleep_req` and `deep_sleep` are both high, and does not rise on `sleep_req` alone. While `pd_active` is high, a `wake_irq` clears it on the next edge.
- R7: While `pd_active` is high, status bits 0, 2 and 4 and the outputs `xtal_osc_on` and `frc_osc_on` are 0. Status bit 3 is unaffected.
- R8: After wake-up, each source that is still enabled restarts its settle count from zero.
- R9: A change of `pll_ref_sel` clears the PLL flag on the next edge and restarts the PLL count on the new reference.
- R10: Reset (`rst_n` low) clears all counters and flags. The status word reads 0 at once.
- R11: A set flag stays set while its source remains enabled and no low-power entry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock; status, control and low-power state |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_xtal | input | 1 | External crystal clock |
| clk_frc | input | 1 | Fast internal RC clock |
| clk_slow | input | 1 | Slow internal RC clock |
| en_xtal | input | 1 | Crystal enable |
| en_frc | input | 1 | Fast RC enable |
| en_slow | input | 1 | Slow RC enable |
| pll_pd | input | 1 | PLL power-down; 1 disables the PLL |
| pll_ref_sel | input | 1 | PLL reference: 0 crystal, 1 fast RC |
| sleep_req | input | 1 | Sleep request |
| deep_sleep | input | 1 | Deep-sleep control; sleep enters the low-power state only when set |
| wake_irq | input | 1 | Wake interrupt |
| status | output | 5 | Ready flags: bit0 crystal, bit2 PLL, bit3 slow RC, bit4 fast RC, bit1 zero |
| xtal_osc_on | output | 1 | Crystal oscillator enable |
| frc_osc_on | output | 1 | Fast RC oscillator enable |
| pd_active | output | 1 | Low-power state active |

## Verification
If a settle counter is off by one or saturates wrongly, the status bit rises too early or too late. That error shows one threshold period after enable. The bench brackets each rise between the threshold and a few cycles past it. A stale flag or a stale synchronizer stage shows on the first system edge after a disable, a low-power entry or a reference change, when the bit must already read 0. A wrong low-power state shows in `pd_active` and the oscillator enables one cycle after the request or wake. Random traffic checks this against a bench model every cycle.

// File: rtl/osm_pkg.sv
package osm_pkg;
  localparam int unsigned NSRC   = 4;
  localparam int unsigned STAT_W = 5;

  // generate index -> status bit position (neighbours decode these bits)
  localparam int unsigned IDX_XTAL = 0;
  localparam int unsigned IDX_PLL  = 1;
  localparam int unsigned IDX_SLOW = 2;
  localparam int unsigned IDX_FRC  = 3;

  localparam int unsigned POS_XTAL = 0;
  localparam int unsigned POS_PLL  = 2;
  localparam int unsigned POS_SLOW = 3;
  localparam int unsigned POS_FRC  = 4;

  typedef logic [STAT_W-1:0] osc_status_t;

  typedef enum logic {PWR_RUN = 1'b0, PWR_DOWN = 1'b1} pwr_state_e;
endpackage

// File: rtl/settle_counter.sv
// Settle counter in the source clock domain. The local reset asserts
// asynchronously when run drops and releases after SYNC_STAGES source edges.
module settle_counter #(
  parameter int unsigned THRESH      = 256,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic ready
);
  localparam int unsigned CW = (THRESH < 2) ? 1 : $clog2(THRESH + 1);
  localparam logic [CW-1:0] LAST = CW'(THRESH - 1);

  logic                   arst_n;
  logic [SYNC_STAGES-1:0] rel_q;
  logic                   go;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   rdy_q, rdy_d;
  logic                   cnt_en;

  assign arst_n = rst_n & run;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rel_q <= '0;
    else         rel_q <= {rel_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign go     = rel_q[SYNC_STAGES-1];
  assign cnt_en = go & ~rdy_q;

  always_comb begin
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (cnt_en) begin
      cnt_d = cnt_q + CW'(1);
      if (cnt_q == LAST) rdy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign ready = rdy_q;
endmodule

// File: rtl/flag_sync.sv
// Multi-flop synchronizer into the system domain with synchronous clear.
module flag_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb begin
    if (clr) sh_d = '0;
    else     sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pwr_ctrl.sv
// Low-power state and registered per-source run controls.
module pwr_ctrl
  import osm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic deep_sleep,
  input  logic wake_irq,
  input  logic en_xtal,
  input  logic en_frc,
  input  logic en_slow,
  input  logic pll_pd,
  input  logic pll_ref_sel,
  output logic pd_active,
  output logic [NSRC-1:0] run
);
  pwr_state_e      st_q, st_d;
  logic [NSRC-1:0] run_q, run_d;
  logic            sel_q;
  logic            down_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      PWR_RUN:  if (sleep_req && deep_sleep) st_d = PWR_DOWN;
      PWR_DOWN: if (wake_irq)                st_d = PWR_RUN;
      default:                               st_d = PWR_RUN;
    endcase
    down_d = (st_d == PWR_DOWN);
    run_d[IDX_XTAL] = en_xtal & ~down_d;
    run_d[IDX_FRC]  = en_frc  & ~down_d;
    run_d[IDX_SLOW] = en_slow;
    run_d[IDX_PLL]  = ~pll_pd & ~down_d & (pll_ref_sel == sel_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PWR_RUN;
      run_q <= '0;
      sel_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      run_q <= run_d;
      sel_q <= pll_ref_sel;
    end
  end

  assign pd_active = (st_q == PWR_DOWN);
  assign run       = run_q;
endmodule

// File: rtl/osc_ready_monitor.sv
module osc_ready_monitor
  import osm_pkg::*;
#(
  parameter int unsigned XTAL_SETTLE = 4096,
  parameter int unsigned PLL_SETTLE  = 6144,
  parameter int unsigned FRC_SETTLE  = 256,
  parameter int unsigned SLOW_SETTLE = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_sys,
  input  logic       rst_n,
  input  logic       clk_xtal,
  input  logic       clk_frc,
  input  logic       clk_slow,
  input  logic       en_xtal,
  input  logic       en_frc,
  input  logic       en_slow,
  input  logic       pll_pd,
  input  logic       pll_ref_sel,
  input  logic       sleep_req,
  input  logic       deep_sleep,
  input  logic       wake_irq,
  output logic [4:0] status,
  output logic       xtal_osc_on,
  output logic       frc_osc_on,
  output logic       pd_active
);
  localparam int unsigned THR [NSRC] = '{XTAL_SETTLE, PLL_SETTLE, SLOW_SETTLE, FRC_SETTLE};
  localparam int unsigned POS [NSRC] = '{POS_XTAL, POS_PLL, POS_SLOW, POS_FRC};

  logic [NSRC-1:0] run;
  logic [NSRC-1:0] src_clk;
  logic [NSRC-1:0] rdy_src;
  logic [NSRC-1:0] rdy_sys;
  logic            pll_ref_clk;
  osc_status_t     stat_w;

  pwr_ctrl u_pwr (
    .clk        (clk_sys),
    .rst_n      (rst_n),
    .sleep_req  (sleep_req),
    .deep_sleep (deep_sleep),
    .wake_irq   (wake_irq),
    .en_xtal    (en_xtal),
    .en_frc     (en_frc),
    .en_slow    (en_slow),
    .pll_pd     (pll_pd),
    .pll_ref_sel(pll_ref_sel),
    .pd_active  (pd_active),
    .run        (run)
  );

  assign pll_ref_clk       = pll_ref_sel ? clk_frc : clk_xtal;
  assign src_clk[IDX_XTAL] = clk_xtal;
  assign src_clk[IDX_PLL]  = pll_ref_clk;
  assign src_clk[IDX_SLOW] = clk_slow;
  assign src_clk[IDX_FRC]  = clk_frc;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    settle_counter #(
      .THRESH     (THR[i]),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_cnt (
      .clk  (src_clk[i]),
      .rst_n(rst_n),
      .run  (run[i]),
      .ready(rdy_src[i])
    );

    logic sync_q;
    flag_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk_sys),
      .rst_n(rst_n),
      .clr  (~run[i]),
      .d    (rdy_src[i]),
      .q    (sync_q)
    );
    assign rdy_sys[i] = sync_q & run[i];
  end

  always_comb begin
    stat_w = '0;
    for (int i = 0; i < NSRC; i++) stat_w[POS[i]] = rdy_sys[i];
  end

  assign status      = stat_w;
  assign xtal_osc_on = run[IDX_XTAL];
  assign frc_osc_on  = run[IDX_FRC];
endmodule

// File: rtl/osc_ready_monitor_chk.sv
module osc_ready_monitor_chk (
  input logic       clk_sys,
  input logic       rst_n,
  input logic       en_xtal,
  input logic       pll_pd,
  input logic       pll_ref_sel,
  input logic       sleep_req,
  input logic       deep_sleep,
  input logic       wake_irq,
  input logic [4:0] status,
  input logic       xtal_osc_on,
  input logic       frc_osc_on,
  input logic       pd_active
);
  a_r4_bit1_zero: assert property (@(posedge clk_sys) disable iff (!rst_n)
    status[1] == 1'b0);

  a_r5_xtal_disable: assert property (@(posedge clk_sys) disable iff (!rst_n)
    !en_xtal |=> !status[0]);

  a_r5_pll_disable: assert property (@(posedge clk_sys) disable iff (!rst_n)
    pll_pd |=> !status[2]);

  a_r6_enter: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (!pd_active && sleep_req && deep_sleep) |=> pd_active);

  a_r6_stay_run: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (!pd_active && !(sleep_req && deep_sleep)) |=> !pd_active);

  a_r6_wake: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (pd_active && wake_irq) |=> !pd_active);

  a_r7_gates_off: assert property (@(posedge clk_sys) disable iff (!rst_n)
    pd_active |-> (!xtal_osc_on && !frc_osc_on));

  a_r7_flags_off: assert property (@(posedge clk_sys) disable iff (!rst_n)
    pd_active |-> (!status[0] && !status[2] && !status[4]));

  a_r9_sel_change: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (pll_ref_sel != $past(pll_ref_sel)) |=> !status[2]);

  a_r11_xtal_hold: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (status[0] && en_xtal && !pd_active && !(sleep_req && deep_sleep)) |=> status[0]);
endmodule

bind osc_ready_monitor osc_ready_monitor_chk u_chk (
  .clk_sys    (clk_sys),
  .rst_n      (rst_n),
  .en_xtal    (en_xtal),
  .pll_pd     (pll_pd),
  .pll_ref_sel(pll_ref_sel),
  .sleep_req  (sleep_req),
  .deep_sleep (deep_sleep),
  .wake_irq   (wake_irq),
  .status     (status),
  .xtal_osc_on(xtal_osc_on),
  .frc_osc_on (frc_osc_on),
  .pd_active  (pd_active)
);

// File: tb/osc_ready_monitor_tb.sv
module osc_ready_monitor_tb;
  logic clk_sys = 0, clk_xtal = 0, clk_frc = 0, clk_slow = 0;
  logic rst_n;
  logic en_xtal, en_frc, en_slow, pll_pd, pll_ref_sel;
  logic sleep_req, deep_sleep, wake_irq;
  logic [4:0] status;
  logic xtal_osc_on, frc_osc_on, pd_active;

  int total = 0, bad = 0;
  int n_x = 0, n_f = 0, n_s = 0;
  bit done = 0;

  always #2.5 clk_sys  = ~clk_sys;
  always #4   clk_xtal = ~clk_xtal;
  always #6   clk_frc  = ~clk_frc;
  always #25  clk_slow = ~clk_slow;

  always @(posedge clk_xtal) n_x++;
  always @(posedge clk_frc)  n_f++;
  always @(posedge clk_slow) n_s++;

  osc_ready_monitor u_dut (
    .clk_sys(clk_sys), .rst_n(rst_n), .clk_xtal(clk_xtal), .clk_frc(clk_frc),
    .clk_slow(clk_slow), .en_xtal(en_xtal), .en_frc(en_frc), .en_slow(en_slow),
    .pll_pd(pll_pd), .pll_ref_sel(pll_ref_sel), .sleep_req(sleep_req),
    .deep_sleep(deep_sleep), .wake_irq(wake_irq), .status(status),
    .xtal_osc_on(xtal_osc_on), .frc_osc_on(frc_osc_on), .pd_active(pd_active)
  );

  task automatic chk(string rq, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int edges(int src);
    case (src)
      0:       return n_x;
      1:       return n_f;
      default: return n_s;
    endcase
  endfunction

  // expected pd state after one edge
  function automatic bit pd_next(bit pd, bit slp, bit dp, bit wk);
    return pd ? !wk : (slp && dp);
  endfunction

  // call on the negedge where the source was (re)started
  task automatic settle_check(int bitn, int src, int thr, string rq);
    int base;
    base = edges(src);
    repeat (2) @(negedge clk_sys);
    chk({rq, " low just after start"}, status[bitn], 0);
    do @(negedge clk_sys); while (edges(src) < base + thr);
    chk({rq, " low at threshold"}, status[bitn], 0);
    do @(negedge clk_sys); while (edges(src) < base + thr + 4);
    repeat (4) @(negedge clk_sys);
    chk({rq, " high after threshold"}, status[bitn], 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(950_000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    bit pd_m, ex, ef, es, sl, dp, wk;
    void'($urandom(32'h1d2c3b4a));
    rst_n = 0; en_xtal = 0; en_frc = 0; en_slow = 0; pll_pd = 1;
    pll_ref_sel = 1; sleep_req = 0; deep_sleep = 0; wake_irq = 0;
    repeat (4) @(negedge clk_sys);
    chk("R10 status in reset", status, 0);
    chk("R10 pd_active in reset", pd_active, 0);
    chk("R10 osc enables in reset", {xtal_osc_on, frc_osc_on}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk_sys);

    en_xtal = 1;
    settle_check(0, 0, 4096, "R1 crystal");
    en_frc = 1;
    settle_check(4, 1, 256, "R2 fast RC");
    en_slow = 1;
    settle_check(3, 2, 1, "R2 slow RC");

    pll_pd = 0;  // reference = fast RC (sel 1)
    settle_check(2, 1, 6144, "R3 PLL on fast RC");
    chk("R4 full status word", status, 5'b11101);
    chk("R4 bit1 zero", status[1], 0);

    repeat (2000) @(negedge clk_sys);
    chk("R11 flags held", status, 5'b11101);

    pll_ref_sel = 0;  // switch to crystal reference
    settle_check(2, 0, 6144, "R9 PLL restart on crystal");
    chk("R3 PLL ready on crystal ref", status[2], 1);

    en_frc = 0;
    @(negedge clk_sys);
    chk("R5 fast RC flag cleared", status[4], 0);
    chk("R5 fast RC osc off", frc_osc_on, 0);
    en_frc = 1;
    settle_check(4, 1, 256, "R5 fast RC recount");
    pll_pd = 1;
    @(negedge clk_sys);
    chk("R5 PLL cleared by power-down control", status[2], 0);

    sleep_req = 1; deep_sleep = 0;
    @(negedge clk_sys);
    sleep_req = 0;
    @(negedge clk_sys);
    chk("R6 no entry without deep-sleep", pd_active, 0);
    sleep_req = 1; deep_sleep = 1;
    @(negedge clk_sys);
    sleep_req = 0;
    chk("R6 entry", pd_active, 1);
    chk("R7 only slow RC flag", status, 5'b01000);
    chk("R7 oscillators gated", {xtal_osc_on, frc_osc_on}, 0);
    repeat (20) @(negedge clk_sys);
    chk("R6 stays down", pd_active, 1);
    chk("R7 slow RC unaffected", status[3], 1);
    wake_irq = 1;
    @(negedge clk_sys);
    wake_irq = 0;
    chk("R6 wake", pd_active, 0);
    chk("R8 crystal osc back on", xtal_osc_on, 1);
    settle_check(0, 0, 4096, "R8 crystal recount after wake");

    // random traffic against a cycle model
    deep_sleep = 0; sleep_req = 0; wake_irq = 0;
    @(negedge clk_sys);
    pd_m = pd_active;
    ex = en_xtal; ef = en_frc; es = en_slow;
    for (int it = 0; it < 3000; it++) begin
      sl = ($urandom % 8) == 0;
      dp = $urandom % 2;
      wk = ($urandom % 16) == 0;
      if (($urandom % 32) == 0) ex = !ex;
      if (($urandom % 32) == 0) ef = !ef;
      if (($urandom % 32) == 0) es = !es;
      sleep_req = sl; deep_sleep = dp; wake_irq = wk;
      en_xtal = ex; en_frc = ef; en_slow = es;
      @(negedge clk_sys);
      pd_m = pd_next(pd_m, sl, dp, wk);
      chk("R6 random pd state", pd_active, pd_m);
      chk("R7 random crystal osc", xtal_osc_on, ex && !pd_m);
      chk("R7 random fast RC osc", frc_osc_on, ef && !pd_m);
      chk("R4 random bit1", status[1], 0);
      if (!(ex && !pd_m)) chk("R5 random crystal flag", status[0], 0);
      if (!(ef && !pd_m)) chk("R5 random fast RC flag", status[4], 0);
      if (!es)            chk("R5 random slow RC flag", status[3], 0);
      chk("R5 random PLL off", status[2], 0);
    end

    sleep_req = 0; wake_irq = 1; en_slow = 1;
    repeat (20) @(negedge clk_sys);
    rst_n = 0;
    #1;
    chk("R10 reset mid-run", status, 0);
    chk("R10 reset clears pd", pd_active, 0);
    finish_run();
  end
endmodule